// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the three integer dividers of a frequency synthesizer: a post divider, a reference divider and a feedback divider. The goal is that the synthesized clock lands as close as possible to a requested pixel clock. It takes four inputs, all in kHz: the target frequency, the reference frequency, and the lowest and highest allowed VCO frequencies.

A pulse on `start` latches the inputs and begins a sequential search. The search first forms the target-to-reference ratio in fixed point, with 16 fractional bits. It then walks the post divider in an outer loop and the reference divider in an inner loop. For each candidate it rounds the feedback divider, applies the feedback limits, and works out the frequency error. It keeps the candidate with the smallest error.

The block has one serial divider. That divider forms both the ratio and every candidate's synthesized frequency. When the search ends, the block pulses `done` and presents the winning dividers, their error and a success or failure flag. The reference frequency must not be zero.

Top module: `pll_div_search`

## Requirements
- R1: A `start` seen while idle latches the four inputs and raises `busy` from the next cycle. `busy` stays high until the search ends. `done` is then high for exactly one cycle with `busy` low. A `start` while `busy` is high is ignored, and the result then depends only on the inputs latched at the accepted start.
- R2: The post divider takes the values 2, 3, ... while it stays strictly below POST_LIM. For each post divider the VCO frequency is target × post. A VCO frequency at or below the minimum skips that post divider.
- R3: A VCO frequency at or above the maximum ends the whole search at once. No larger post divider is tried.
- R4: For each post divider that is not skipped, the reference divider takes every value from 1 to REF_LIM inclusive, unless R6 or R8 cuts the loop short.
- R5: The feedback divider is floor((ratio × post × refdiv + 2^15) / 2^16), where ratio = floor(target × 2^16 / reference).
- R6: The inner loop ends, and the next post divider follows, as soon as a feedback divider is at least FB_LIM (default 1024). It also ends as soon as a feedback divider exceeds 500 + 13 × refdiv.
- R7: The error is |target − floor(fb × reference / (post × refdiv))|. A candidate replaces the stored best only when its error is strictly smaller, so on a tie the earlier candidate wins.
- R8: A candidate with error zero ends the search immediately and is reported.
- R9: The best error starts at all ones (2^31 − 1 by default). If no candidate was stored, the block reports `fail`=1 and `ok`=0, with the error all ones and all three dividers zero. Otherwise it reports `ok`=1 and `fail`=0. `ok` and `fail` never both read 1.
- R10: After reset all outputs are zero. The result outputs change only in the cycle `done` is high, and they hold until the next search completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search when idle |
| target_khz | input | FREQ_W | Requested output frequency |
| ref_khz | input | FREQ_W | Reference frequency, nonzero |
| vco_min_khz | input | FREQ_W | VCO lower bound (exclusive) |
| vco_max_khz | input | FREQ_W | VCO upper bound (exclusive) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| post_div | output | $clog2(POST_LIM+1) | Chosen post divider |
| ref_div | output | $clog2(REF_LIM+1) | Chosen reference divider |
| fb_div | output | $clog2(FB_LIM) | Chosen feedback divider |
| err_khz | output | $clog2(FB_LIM)+FREQ_W | Absolute error of the chosen setting |
| ok | output | 1 | A setting was found |
| fail | output | 1 | No setting was found |

## Verification
`busy` is due one cycle after the edge that samples `start`, and the bench reads it at the next falling edge. Completion time depends on how many candidates the loops visit, so the bench polls `done` at every falling edge under a bound. It compares all results in the cycle `done` is first seen. It then expects `done` low one cycle later, and on selected searches it expects every result unchanged over the following idle cycles.

// File: rtl/pds_pkg.sv
package pds_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RATIO,
    S_POST,
    S_FB,
    S_ERR,
    S_FIN
  } pds_state_e;
endpackage

// File: rtl/pds_divider.sv
// Restoring serial divider: one quotient bit per cycle, fin pulses when quo is valid.
module pds_divider #(
  parameter int DW = 37
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [DW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [DW-1:0] quo
);
  localparam int CNTW = $clog2(DW + 1);

  logic [DW-1:0]   rem_q;
  logic [DW-1:0]   den_q;
  logic [CNTW-1:0] cnt_q;
  logic            act_q;
  logic [DW:0]     shifted;
  logic [DW:0]     trial;
  logic            fits;

  always_comb begin
    shifted = {rem_q, quo[DW-1]};
    trial   = shifted - {1'b0, den_q};
    fits    = (shifted >= {1'b0, den_q});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      den_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
      fin   <= 1'b0;
      quo   <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        quo   <= num;
        den_q <= den;
        rem_q <= '0;
        cnt_q <= CNTW'(DW);
        act_q <= 1'b1;
      end else if (act_q) begin
        if (fits) begin
          rem_q <= trial[DW-1:0];
          quo   <= {quo[DW-2:0], 1'b1};
        end else begin
          rem_q <= shifted[DW-1:0];
          quo   <= {quo[DW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CNTW'(1);
        if (cnt_q == CNTW'(1)) begin
          act_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pds_fb_calc.sv
// Rounds the feedback divider for one candidate and flags it against both limits.
module pds_fb_calc #(
  parameter int RTW      = 37,
  parameter int PW       = 4,
  parameter int RW       = 4,
  parameter int FRAC_W   = 16,
  parameter int FBW      = 10,
  parameter int FB_LIM   = 1024,
  parameter int FB_BASE  = 500,
  parameter int FB_SLOPE = 13
) (
  input  logic [RTW-1:0] ratio,
  input  logic [PW-1:0]  post,
  input  logic [RW-1:0]  refd,
  output logic [FBW-1:0] fb,
  output logic           reject
);
  localparam int PRW = RTW + PW + RW + 1;

  logic [PRW-1:0] scaled;
  logic [PRW-1:0] fb_full;
  logic [PRW-1:0] slope_lim;

  always_comb begin
    scaled    = PRW'(ratio) * PRW'(post) * PRW'(refd) + (PRW'(1) << (FRAC_W - 1));
    fb_full   = scaled >> FRAC_W;
    slope_lim = PRW'(FB_BASE) + PRW'(FB_SLOPE) * PRW'(refd);
    reject    = (fb_full >= PRW'(FB_LIM)) || (fb_full > slope_lim);
    fb        = fb_full[FBW-1:0];
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
  import pds_pkg::*;
#(
  parameter int FREQ_W   = 21,
  parameter int FRAC_W   = 16,
  parameter int POST_LIM = 8,
  parameter int REF_LIM  = 8,
  parameter int FB_LIM   = 1024,
  parameter int FB_BASE  = 500,
  parameter int FB_SLOPE = 13
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                start,
  input  logic [FREQ_W-1:0]                   target_khz,
  input  logic [FREQ_W-1:0]                   ref_khz,
  input  logic [FREQ_W-1:0]                   vco_min_khz,
  input  logic [FREQ_W-1:0]                   vco_max_khz,
  output logic                                busy,
  output logic                                done,
  output logic [$clog2(POST_LIM+1)-1:0]       post_div,
  output logic [$clog2(REF_LIM+1)-1:0]        ref_div,
  output logic [$clog2(FB_LIM)-1:0]           fb_div,
  output logic [$clog2(FB_LIM)+FREQ_W-1:0]    err_khz,
  output logic                                ok,
  output logic                                fail
);
  localparam int PW  = $clog2(POST_LIM + 1);
  localparam int RW  = $clog2(REF_LIM + 1);
  localparam int FBW = $clog2(FB_LIM);
  localparam int EW  = FBW + FREQ_W;
  localparam int RTW = FREQ_W + FRAC_W;
  localparam int DW  = (RTW > EW) ? RTW : EW;
  localparam int CW  = FREQ_W + PW;

  pds_state_e         st;
  logic [FREQ_W-1:0]  tgt_q, ref_q, vmin_q, vmax_q;
  logic [RTW-1:0]     ratio_q;
  logic [PW-1:0]      p_q;
  logic [RW-1:0]      r_q;
  logic [FBW-1:0]     fb_try;
  logic [EW-1:0]      best_e;
  logic [PW-1:0]      best_p;
  logic [RW-1:0]      best_r;
  logic [FBW-1:0]     best_f;

  logic               div_go;
  logic [DW-1:0]      div_num, div_den, div_quo;
  logic               div_fin;

  logic [FBW-1:0]     fb_cand;
  logic               fb_reject;
  logic [CW-1:0]      vco;
  logic [DW-1:0]      tgt_ext, diff;
  logic               better;

  pds_divider #(.DW(DW)) u_div (
    .clk (clk),
    .rst (rst),
    .go  (div_go),
    .num (div_num),
    .den (div_den),
    .fin (div_fin),
    .quo (div_quo)
  );

  pds_fb_calc #(
    .RTW(RTW), .PW(PW), .RW(RW), .FRAC_W(FRAC_W), .FBW(FBW),
    .FB_LIM(FB_LIM), .FB_BASE(FB_BASE), .FB_SLOPE(FB_SLOPE)
  ) u_fb (
    .ratio  (ratio_q),
    .post   (p_q),
    .refd   (r_q),
    .fb     (fb_cand),
    .reject (fb_reject)
  );

  always_comb begin
    vco     = CW'(tgt_q) * CW'(p_q);
    tgt_ext = DW'(tgt_q);
    diff    = (div_quo > tgt_ext) ? (div_quo - tgt_ext) : (tgt_ext - div_quo);
    better  = (diff < DW'(best_e));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      tgt_q    <= '0;
      ref_q    <= '0;
      vmin_q   <= '0;
      vmax_q   <= '0;
      ratio_q  <= '0;
      p_q      <= '0;
      r_q      <= '0;
      fb_try   <= '0;
      best_e   <= '1;
      best_p   <= '0;
      best_r   <= '0;
      best_f   <= '0;
      div_go   <= 1'b0;
      div_num  <= '0;
      div_den  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      post_div <= '0;
      ref_div  <= '0;
      fb_div   <= '0;
      err_khz  <= '0;
      ok       <= 1'b0;
      fail     <= 1'b0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            tgt_q   <= target_khz;
            ref_q   <= ref_khz;
            vmin_q  <= vco_min_khz;
            vmax_q  <= vco_max_khz;
            best_e  <= '1;
            best_p  <= '0;
            best_r  <= '0;
            best_f  <= '0;
            p_q     <= PW'(2);
            r_q     <= RW'(1);
            div_num <= DW'({target_khz, {FRAC_W{1'b0}}});
            div_den <= DW'(ref_khz);
            div_go  <= 1'b1;
            busy    <= 1'b1;
            st      <= S_RATIO;
          end
        end
        S_RATIO: begin
          if (div_fin) begin
            ratio_q <= div_quo[RTW-1:0];
            st      <= S_POST;
          end
        end
        S_POST: begin
          if (p_q >= PW'(POST_LIM)) begin
            st <= S_FIN;
          end else if (vco <= CW'(vmin_q)) begin
            p_q <= p_q + PW'(1);
          end else if (vco >= CW'(vmax_q)) begin
            st <= S_FIN;
          end else begin
            r_q <= RW'(1);
            st  <= S_FB;
          end
        end
        S_FB: begin
          if (fb_reject) begin
            p_q <= p_q + PW'(1);
            st  <= S_POST;
          end else begin
            fb_try  <= fb_cand;
            div_num <= DW'(EW'(fb_cand) * EW'(ref_q));
            div_den <= DW'((PW + RW)'(p_q) * (PW + RW)'(r_q));
            div_go  <= 1'b1;
            st      <= S_ERR;
          end
        end
        S_ERR: begin
          if (div_fin) begin
            if (better) begin
              best_e <= diff[EW-1:0];
              best_p <= p_q;
              best_r <= r_q;
              best_f <= fb_try;
            end
            if (better && (diff == '0)) begin
              st <= S_FIN;
            end else if (r_q == RW'(REF_LIM)) begin
              p_q <= p_q + PW'(1);
              st  <= S_POST;
            end else begin
              r_q <= r_q + RW'(1);
              st  <= S_FB;
            end
          end
        end
        S_FIN: begin
          post_div <= best_p;
          ref_div  <= best_r;
          fb_div   <= best_f;
          err_khz  <= best_e;
          ok       <= (best_e != '1);
          fail     <= (best_e == '1);
          done     <= 1'b1;
          busy     <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pds_chk.sv
module pds_chk #(
  parameter int FREQ_W   = 21,
  parameter int POST_LIM = 8,
  parameter int REF_LIM  = 8,
  parameter int FB_LIM   = 1024,
  parameter int FB_BASE  = 500,
  parameter int FB_SLOPE = 13
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             busy,
  input logic                             done,
  input logic [$clog2(POST_LIM+1)-1:0]    post_div,
  input logic [$clog2(REF_LIM+1)-1:0]     ref_div,
  input logic [$clog2(FB_LIM)-1:0]        fb_div,
  input logic [$clog2(FB_LIM)+FREQ_W-1:0] err_khz,
  input logic                             ok,
  input logic                             fail
);
  localparam int LW = 32;

  // R1
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R1
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy);

  // R1
  busy_end_chk: assert property (@(posedge clk) disable iff (rst) $fell(busy) |-> done);

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst) done |-> (ok ^ fail));

  // R9
  fail_shape_chk: assert property (@(posedge clk) disable iff (rst)
    fail |-> ((err_khz == '1) && (post_div == '0) && (ref_div == '0) && (fb_div == '0)));

  // R6
  win_range_chk: assert property (@(posedge clk) disable iff (rst)
    ok |-> ((LW'(post_div) >= 2) && (LW'(post_div) < LW'(POST_LIM)) &&
            (LW'(ref_div) >= 1) && (LW'(ref_div) <= LW'(REF_LIM)) &&
            (LW'(fb_div) <= LW'(FB_BASE) + LW'(FB_SLOPE) * LW'(ref_div)) &&
            (err_khz != '1)));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(post_div) && $stable(ref_div) && $stable(fb_div) &&
               $stable(err_khz) && $stable(ok) && $stable(fail)));
endmodule

bind pll_div_search pds_chk #(
  .FREQ_W(FREQ_W), .POST_LIM(POST_LIM), .REF_LIM(REF_LIM),
  .FB_LIM(FB_LIM), .FB_BASE(FB_BASE), .FB_SLOPE(FB_SLOPE)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .post_div (post_div),
  .ref_div  (ref_div),
  .fb_div   (fb_div),
  .err_khz  (err_khz),
  .ok       (ok),
  .fail     (fail)
);

// File: tb/sim_pll_div_search.sv
module sim_pll_div_search;
  localparam int FREQ_W   = 21;
  localparam int POST_LIM = 8;
  localparam int REF_LIM  = 8;
  localparam int FB_LIM   = 1024;
  localparam int FBW      = $clog2(FB_LIM);
  localparam int EW       = FBW + FREQ_W;
  localparam longint ALL1 = (64'sd1 <<< EW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [FREQ_W-1:0] target_khz = '0, ref_khz = '0, vco_min_khz = '0, vco_max_khz = '0;
  logic busy, done, ok, fail;
  logic [$clog2(POST_LIM+1)-1:0] post_div;
  logic [$clog2(REF_LIM+1)-1:0]  ref_div;
  logic [FBW-1:0]                fb_div;
  logic [EW-1:0]                 err_khz;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  pll_div_search #(
    .FREQ_W(FREQ_W), .POST_LIM(POST_LIM), .REF_LIM(REF_LIM), .FB_LIM(FB_LIM)
  ) u0 (
    .clk(clk), .rst(rst), .start(start),
    .target_khz(target_khz), .ref_khz(ref_khz),
    .vco_min_khz(vco_min_khz), .vco_max_khz(vco_max_khz),
    .busy(busy), .done(done), .post_div(post_div), .ref_div(ref_div),
    .fb_div(fb_div), .err_khz(err_khz), .ok(ok), .fail(fail)
  );

  task automatic chk_eq(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model(input longint tgt, input longint rf, input longint vmn, input longint vmx,
                       output longint bp, output longint br, output longint bf,
                       output longint be, output bit okv);
    longint ratio;
    bit stop;
    ratio = (tgt <<< 16) / rf;
    be = ALL1; bp = 0; br = 0; bf = 0; stop = 0;
    for (longint p = 2; p < POST_LIM && !stop; p++) begin
      longint vco;
      vco = tgt * p;
      if (vco > vmn) begin
        if (vco >= vmx) stop = 1;
        for (longint r = 1; r <= REF_LIM && !stop; r++) begin
          longint fb, q, d;
          fb = (ratio * p * r + 32768) >>> 16;
          if (fb >= FB_LIM || fb > 500 + 13 * r) break;
          q = (fb * rf) / (p * r);
          d = (tgt > q) ? tgt - q : q - tgt;
          if (d < be) begin
            be = d; bp = p; br = r; bf = fb;
          end
          if (be == 0) stop = 1;
        end
      end
    end
    okv = (be != ALL1);
  endtask

  task automatic run(input longint tgt, input longint rf, input longint vmn, input longint vmx,
                     input string tag, input bit hold, input bit poke);
    longint ep, er, ef, ee;
    bit eok;
    int cyc;
    model(tgt, rf, vmn, vmx, ep, er, ef, ee, eok);
    @(negedge clk);
    target_khz = FREQ_W'(tgt); ref_khz = FREQ_W'(rf);
    vco_min_khz = FREQ_W'(vmn); vco_max_khz = FREQ_W'(vmx);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_eq("R1 busy after start", busy, 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      target_khz = FREQ_W'(tgt + 7777); ref_khz = FREQ_W'(rf + 333);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk_eq("R1 still busy after ignored start", busy, 1);
    end
    cyc = 0;
    while (done !== 1'b1 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk_eq("R1 search completes", done, 1);
    chk_eq("R1 busy low with done", busy, 0);
    chk_eq({tag, " R9 ok flag"}, ok, eok);
    chk_eq({tag, " R9 fail flag"}, fail, !eok);
    chk_eq({tag, " R2 post divider"}, post_div, ep);
    chk_eq({tag, " R4 reference divider"}, ref_div, er);
    chk_eq({tag, " R5 feedback divider"}, fb_div, ef);
    chk_eq({tag, " R7 error"}, err_khz, ee);
    @(negedge clk);
    chk_eq("R1 done lasts one cycle", done, 0);
    if (hold) begin
      repeat (5) @(negedge clk);
      chk_eq("R10 post held", post_div, ep);
      chk_eq("R10 fb held", fb_div, ef);
      chk_eq("R10 error held", err_khz, ee);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    chk_eq("R10 reset busy", busy, 0);
    chk_eq("R10 reset done", done, 0);
    chk_eq("R10 reset ok", ok, 0);
    chk_eq("R10 reset fail", fail, 0);
    chk_eq("R10 reset error", err_khz, 0);
    chk_eq("R10 reset post", post_div, 0);
    rst = 1'b0;

    // R8: exact hit at the very first candidate
    run(13500, 27000, 20000, 500000, "exact", 1, 0);
    chk_eq("R8 exact post", post_div, 2);
    chk_eq("R8 exact ref", ref_div, 1);
    chk_eq("R8 exact fb", fb_div, 1);
    chk_eq("R8 exact error", err_khz, 0);

    // R9: zero target never clears the VCO floor
    run(0, 27000, 1000, 500000, "zero", 0, 0);
    chk_eq("R9 zero target fails", fail, 1);
    chk_eq("R9 error all ones", err_khz, ALL1);

    // R3: first VCO already at the ceiling
    run(100000, 27000, 50000, 200000, "ceiling", 0, 0);
    chk_eq("R3 ceiling ends search", fail, 1);

    // R2: posts 2..5 skipped by the floor
    run(50000, 27000, 260000, 1000000, "floor", 0, 0);
    n_chk++;
    if (post_div < 6) begin
      n_fail++;
      $display("FAIL R2 floor skip actual=%0d expected=6 or more", post_div);
    end

    // R6: every feedback value over its limit
    run(400000, 1000, 100000, 2000000, "fblimit", 0, 0);
    chk_eq("R6 feedback limit fails", fail, 1);

    // R1: start while busy is ignored
    run(148500, 27000, 400000, 1100000, "poke", 1, 1);

    for (int i = 0; i < 16; i++) begin
      longint t, rf, vmn, vmx;
      rf  = 10000 + ($urandom % 90000);
      t   = 10000 + ($urandom % 300000);
      vmn = 100000 + ($urandom % 300000);
      vmx = vmn + 200000 + ($urandom % 800000);
      run(t, rf, vmn, vmx, "random", (i % 4) == 0, 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule